// File: doc/BRIEF.md
# Operator Self-Check Signature Collector

This block sits beside a chain of up to eight arithmetic operators and lets a test controller check all of them at once, then inspect any one of them in detail. Every operator has one result register. The register either follows the operator's functional output or is written from a shared write bus. During a global check the controller first writes each operator's expected answer into its register and drives the test operands. It then issues a one-cycle confirm strobe. At the strobe, each enabled operator's live result is compared against the value held in its register.

Each comparison updates one bit of a signature word. A bit that records a failure stays low until the signature is read, so one read after a long run still shows every operator that ever failed. Once a failing operator is known, the controller selects it and drives its register onto a read bus that feeds a serial port, either as stored or after capturing the operator's live output. With test mode off, the registers simply follow the operators and the signature is frozen.

Top module: `opsig_collector`

## Requirements
- R1: During and after reset, and before any test cycle, `signature` is all ones, every register word in `reg_q` is zero, and `bus_rdata`/`bus_valid` are zero.
- R2: With `test_mode` low, every register captures its own `op_result` word on each clock edge, and `signature` keeps its value even if `confirm` or `sig_rd` is high.
- R3: With `test_mode` high and `rw` = 2'b01, the register selected by `sel_op` loads `bus_wdata` on the clock edge, and all other registers hold.
- R4: With `test_mode` high, `rw` = 2'b10 makes the selected register capture its `op_result` word. `rw` = 2'b00 holds every register, and registers that are not selected always hold.
- R5: With `test_mode` high and `rw` = 2'b11, `bus_rdata` shows the selected register in the same cycle and `bus_valid` is 1, while the register holds. In every other case `bus_rdata` is zero and `bus_valid` is 0.
- R6: A `confirm` cycle with `test_mode` high clears signature bit i when `op_enable[i]` is 1 and the `op_result` word i differs from register word i. A matching or disabled operator leaves its bit unchanged.
- R7: A signature bit at 0 stays 0 through later matching confirms until a read.
- R8: A `sig_rd` cycle with `test_mode` high shows the current signature in that cycle and sets all bits to 1 at the next edge. If `confirm` is high in the same cycle, enabled mismatching operators are cleared after that restore.
- R9: Operator i owns signature bit i and bits [i*DATA_W +: DATA_W] of `op_result` and `reg_q`. `sel_op` = i selects operator i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Test mode enable |
| sel_op | input | SEL_W | Selected operator index |
| rw | input | 2 | Register action code for the selected operator |
| bus_wdata | input | DATA_W | Write bus value |
| op_result | input | NUM_OPS*DATA_W | Functional results of the operators |
| op_enable | input | NUM_OPS | Operators taking part in a confirm |
| confirm | input | 1 | One-cycle compare strobe |
| sig_rd | input | 1 | Signature read strobe |
| reg_q | output | NUM_OPS*DATA_W | Register contents |
| signature | output | NUM_OPS | Pass/fail bit per operator |
| bus_rdata | output | DATA_W | Read bus toward the serial port |
| bus_valid | output | 1 | Read bus carries a register |

## Verification
The bench targets these corner cases:
- A failed bit that is followed by a passing confirm. A non-sticky design would wrongly report the operator as healthy.
- A confirm on a disabled operator whose result is wrong. A design ignoring `op_enable` would flag it.
- A read and a confirm in the same cycle. If the restore and the compare are ordered wrongly, the new failure is lost or the old one survives.
- Reads and confirms with test mode off. A design that does not freeze the signature would lose its failure record.
- The read bus is checked during and after a drive cycle, and the bench confirms that driving does not disturb the stored word.

// File: rtl/opsig_pkg.sv
`timescale 1ns/1ps
package opsig_pkg;
  typedef enum logic [1:0] {
    RW_HOLD  = 2'b00,
    RW_LOAD  = 2'b01,
    RW_CAPT  = 2'b10,
    RW_DRIVE = 2'b11
  } rw_code_e;
endpackage

// File: rtl/opsig_reg_cell.sv
`timescale 1ns/1ps
module opsig_reg_cell
  import opsig_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              sel,
  input  logic [1:0]        rw_code,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] func_in,
  output logic [DATA_W-1:0] q
);
  logic load_ev;
  logic capt_ev;
  logic pass_ev;

  assign pass_ev = !test_mode;
  assign load_ev = test_mode && sel && (rw_code == RW_LOAD);
  assign capt_ev = test_mode && sel && (rw_code == RW_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (pass_ev) q <= func_in;
    else if (load_ev) q <= bus_wdata;
    else if (capt_ev) q <= func_in;
  end

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> q == $past(func_in));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && sel && rw_code == RW_LOAD) |=> q == $past(bus_wdata));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !(sel && (rw_code == RW_LOAD || rw_code == RW_CAPT))) |=> $stable(q));
endmodule

// File: rtl/opsig_signature.sv
`timescale 1ns/1ps
module opsig_signature #(
  parameter int NUM_OPS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_mode,
  input  logic               confirm,
  input  logic               sig_rd,
  input  logic [NUM_OPS-1:0] op_enable,
  input  logic [NUM_OPS-1:0] match,
  output logic [NUM_OPS-1:0] sig_q
);
  logic               rd_ev;
  logic               cf_ev;
  logic [NUM_OPS-1:0] base;
  logic [NUM_OPS-1:0] fail_mask;
  logic [NUM_OPS-1:0] sig_d;

  assign rd_ev = test_mode && sig_rd;
  assign cf_ev = test_mode && confirm;

  function automatic logic [NUM_OPS-1:0] fails(input logic [NUM_OPS-1:0] en,
                                               input logic [NUM_OPS-1:0] ok);
    return en & ~ok;
  endfunction

  always_comb begin
    base      = rd_ev ? {NUM_OPS{1'b1}} : sig_q;
    fail_mask = cf_ev ? fails(op_enable, match) : '0;
    sig_d     = base & ~fail_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sig_q <= {NUM_OPS{1'b1}};
    else if (test_mode) sig_q <= sig_d;
  end

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> $stable(sig_q));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> ((sig_q & ~$past(sig_q)) == '0));
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !cf_ev) |=> (sig_q == {NUM_OPS{1'b1}}));

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_bit
    p_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_ev && op_enable[i] && !match[i]) |=> !sig_q[i]);
    p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !rd_ev && !(cf_ev && op_enable[i] && !match[i])) |=> (sig_q[i] == $past(sig_q[i])));
  end
endmodule

// File: rtl/opsig_bus_mux.sv
`timescale 1ns/1ps
module opsig_bus_mux #(
  parameter int NUM_OPS = 8,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic [NUM_OPS*DATA_W-1:0] words,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      drive,
  output logic [DATA_W-1:0]         data,
  output logic                      valid
);
  logic [NUM_OPS-1:0] hit;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_hit
    assign hit[i] = drive && (sel == SEL_W'(i));
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_OPS; i++)
      if (hit[i]) data = data | words[i*DATA_W +: DATA_W];
  end

  assign valid = |hit;
endmodule

// File: rtl/opsig_collector.sv
`timescale 1ns/1ps
module opsig_collector
  import opsig_pkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int FLAT_W = NUM_OPS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_mode,
  input  logic [SEL_W-1:0]   sel_op,
  input  logic [1:0]         rw,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [FLAT_W-1:0]  op_result,
  input  logic [NUM_OPS-1:0] op_enable,
  input  logic               confirm,
  input  logic               sig_rd,
  output logic [FLAT_W-1:0]  reg_q,
  output logic [NUM_OPS-1:0] signature,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_valid
);
  logic [NUM_OPS-1:0] sel_hit;
  logic [NUM_OPS-1:0] match;
  logic               drive_ev;

  function automatic logic words_equal(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    return a == b;
  endfunction

  assign drive_ev = test_mode && (rw == RW_DRIVE);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    assign sel_hit[i] = (sel_op == SEL_W'(i));
    assign match[i]   = words_equal(op_result[i*DATA_W +: DATA_W], reg_q[i*DATA_W +: DATA_W]);

    opsig_reg_cell #(.DATA_W(DATA_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .sel       (sel_hit[i]),
      .rw_code   (rw),
      .bus_wdata (bus_wdata),
      .func_in   (op_result[i*DATA_W +: DATA_W]),
      .q         (reg_q[i*DATA_W +: DATA_W])
    );
  end

  opsig_signature #(.NUM_OPS(NUM_OPS)) u_sig (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .confirm   (confirm),
    .sig_rd    (sig_rd),
    .op_enable (op_enable),
    .match     (match),
    .sig_q     (signature)
  );

  opsig_bus_mux #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W)) u_mux (
    .words (reg_q),
    .sel   (sel_op),
    .drive (drive_ev),
    .data  (bus_rdata),
    .valid (bus_valid)
  );

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_ev |-> (bus_rdata == '0 && !bus_valid));
  p_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ev && (sel_op < SEL_W'(NUM_OPS - 1) || sel_op == SEL_W'(NUM_OPS - 1))) |-> bus_valid);
  p_drive_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_ev |=> $stable(reg_q));
endmodule

// File: tb/opsig_collector_test.sv
`timescale 1ns/1ps
module opsig_collector_test;
  localparam int N = 8;
  localparam int W = 8;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           test_mode = 0;
  logic [2:0]     sel_op = 0;
  logic [1:0]     rw = 0;
  logic [W-1:0]   bus_wdata = 0;
  logic [N*W-1:0] op_result;
  logic [N-1:0]   op_enable = '1;
  logic           confirm = 0;
  logic           sig_rd = 0;
  logic [N*W-1:0] reg_q;
  logic [N-1:0]   signature;
  logic [W-1:0]   bus_rdata;
  logic           bus_valid;

  logic [W-1:0] res_a [N];
  logic [W-1:0] m_reg [N];
  logic [N-1:0] m_sig;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) op_result[i*W +: W] = res_a[i];

  opsig_collector #(.NUM_OPS(N), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .sel_op(sel_op), .rw(rw),
    .bus_wdata(bus_wdata), .op_result(op_result), .op_enable(op_enable),
    .confirm(confirm), .sig_rd(sig_rd), .reg_q(reg_q), .signature(signature),
    .bus_rdata(bus_rdata), .bus_valid(bus_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    logic [N-1:0] nx;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_reg[i] = '0;
      m_sig = '1;
    end else begin
      nx = m_sig;
      if (test_mode) begin
        if (sig_rd) nx = '1;
        if (confirm)
          for (int i = 0; i < N; i++)
            if (op_enable[i] && res_a[i] != m_reg[i]) nx[i] = 1'b0;
      end
      for (int i = 0; i < N; i++) begin
        if (!test_mode) m_reg[i] = res_a[i];
        else if (sel_op == i && rw == 2'b01) m_reg[i] = bus_wdata;
        else if (sel_op == i && rw == 2'b10) m_reg[i] = res_a[i];
      end
      m_sig = nx;
    end
  end

  always @(negedge clk) begin
    logic [W-1:0] eb;
    if (!done) begin
      for (int i = 0; i < N; i++) chk("R2/R3/R4 model reg", reg_q[i*W +: W], m_reg[i]);
      chk("R6/R7/R8 model signature", signature, m_sig);
      eb = (test_mode && rw == 2'b11) ? m_reg[sel_op] : '0;
      chk("R5 model bus", {bus_valid, bus_rdata}, {(test_mode && rw == 2'b11), eb});
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) res_a[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    chk("R1 signature", signature, 8'hFF);
    chk("R1 regs", reg_q, 64'h0);
    chk("R1 bus", {bus_valid, bus_rdata}, 9'h0);

    // R2: functional mode follows operators, strobes ignored
    for (int i = 0; i < N; i++) res_a[i] = 8'h30 + 8'(i);
    confirm = 1; sig_rd = 1;
    tick;
    confirm = 0; sig_rd = 0;
    chk("R2 follow op3", reg_q[3*W +: W], 8'h33);
    chk("R2 signature untouched", signature, 8'hFF);

    // R3: load expected values
    test_mode = 1;
    for (int i = 0; i < N; i++) begin
      sel_op = 3'(i); rw = 2'b01; bus_wdata = 8'h11 * 8'(i + 1);
      tick;
    end
    rw = 2'b00;
    for (int i = 0; i < N; i++) chk("R3 loaded", reg_q[i*W +: W], 8'h11 * 8'(i + 1));

    // R6/R9: op2 mismatch, op5 mismatch but disabled
    for (int i = 0; i < N; i++) res_a[i] = 8'h11 * 8'(i + 1);
    res_a[2] = 8'h00; res_a[5] = 8'h00;
    op_enable = 8'b1101_1111;
    confirm = 1;
    tick;
    confirm = 0;
    chk("R6 R9 bit2 cleared, bit5 skipped", signature, 8'hFB);

    // R7: passing confirm does not restore bit2
    res_a[2] = 8'h33;
    confirm = 1;
    tick;
    confirm = 0;
    chk("R7 sticky bit2", signature, 8'hFB);

    // R5: drive selected register onto read bus
    sel_op = 3'd2; rw = 2'b11;
    #1;
    chk("R5 bus data", bus_rdata, 8'h33);
    chk("R5 bus valid", bus_valid, 1'b1);
    tick;
    chk("R5 reg held", reg_q[2*W +: W], 8'h33);
    rw = 2'b00;
    #1;
    chk("R5 bus idle", {bus_valid, bus_rdata}, 9'h0);

    // R4: capture live result, others hold
    res_a[2] = 8'h5A;
    rw = 2'b10;
    tick;
    rw = 2'b00;
    chk("R4 capture", reg_q[2*W +: W], 8'h5A);
    chk("R4 others hold", reg_q[3*W +: W], 8'h44);
    tick;
    chk("R4 hold code", reg_q[2*W +: W], 8'h5A);

    // R8: read shows value, then restores
    sig_rd = 1;
    #1;
    chk("R8 read value", signature, 8'hFB);
    tick;
    sig_rd = 0;
    chk("R8 restored", signature, 8'hFF);

    // R8: read and confirm together, op4 mismatches
    res_a[4] = 8'h00;
    sig_rd = 1; confirm = 1;
    tick;
    sig_rd = 0; confirm = 0;
    chk("R8 read plus confirm", signature, 8'hEF);

    // R2: freeze with test off
    test_mode = 0;
    sig_rd = 1; confirm = 1;
    tick;
    sig_rd = 0; confirm = 0;
    chk("R2 frozen signature", signature, 8'hEF);
    chk("R2 follow op4", reg_q[4*W +: W], 8'h00);

    tick;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule